// File: doc/BRIEF.md
# Reloadable single-channel PWM generator

This block produces one pulse-width-modulated output from a free-running counter. The counter steps once every 2^p clock cycles, where p is a prescaler code. It counts from 0 up to the modulus minus one and then wraps. The output is high while the count is below the pulse width. Software writes the prescaler, modulus and width into shadow copies over a byte-wide register bus. The working copies change only at a reload point, and only when software has armed the transfer with a load-arm bit. Because all three values change in the same clock edge, the output never shows a period built from a mix of old and new settings.

Reload points come from counter events called opportunities. The counter wrap is always an opportunity. When the half bit is set, the step on which the counter reaches half the modulus is one as well. A rate field sets how many opportunities make up one reload. Every reload sets a flag that drives the interrupt request. The flag is cleared by reading the control register and then writing zero to the flag. This clearing rule is race-safe: a reload that lands between the read and the write cancels the clear.

An external override input can take over the pin whenever the override bit is set.

Top module: `pwm_reload_gen`

## Requirements
- R1: After reset all four registers read 0. The registers are control at address 0, configuration at address 1, modulus shadow at address 2 and width shadow at address 3. pwm_o and irq_o are low.
- R2: While the generator runs with no override, the counter runs from 0 to modulus-1. pwm_o is high while the counter is below the active width, so over whole periods pwm_o is high for width cycles in every modulus cycles. An active width of 0 keeps pwm_o low. A width at or above the modulus keeps pwm_o high.
- R3: Writes to the modulus shadow, the width shadow and the prescaler field leave the output unchanged until a reload occurs with the load-arm bit (control bit 1) set. At that reload all three working values change together.
- R4: The load-arm bit reads 1 once software writes 1. It clears itself at the reload that applies the shadows. Writing 0 to it before that reload cancels the transfer, and the old working values stay.
- R5: Every reload sets the reload flag (control bit 7), whether or not the load-arm bit is set. irq_o is high exactly while the flag is set.
- R6: A write of 0 to the flag clears the flag only if a read of the control register with the flag at 1 came before it. A write of 0 without that read, or a write of 1, leaves the flag and irq_o unchanged.
- R7: When a reload occurs after the qualifying read and before the write of 0, that write leaves the flag set.
- R8: The reload-rate field is configuration bits 3:0, holding code n. A reload happens on every (n+1)-th opportunity. Reads return the code last written. A new code is adopted at the next reload, whether or not the load-arm bit is set.
- R9: With the half bit (control bit 2) clear, the only opportunity is the counter wrap. With it set, the count step that brings the counter to modulus/2 (rounded down) is an extra opportunity. An active modulus of 0 or 1 wraps on every count step, and 0 is the working value after reset.
- R10: While the enable bit (control bit 0) is clear, the prescaler, the counter and the opportunity count are held at zero and pwm_o is low. While the override bit (control bit 3) is set, pwm_o follows ovr_i whatever the enable bit.
- R11: The prescaler field is configuration bits 6:4, holding code p. It is shadowed like the modulus. The counter advances once every 2^p clock cycles, starting from the cycle after enabling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register (combinational) |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| ovr_i | input | 1 | Level driven onto pwm_o while override is selected |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Reload interrupt request |

## Verification
The assertions take for granted that the bus strobes carry known values and are never high in the same cycle. They also assume a read strobe lasts one cycle, so that a single read arms the flag clear only once. ovr_i is taken to be a known level whenever the override bit is set. The driver tasks raise one strobe at a time, shortly after a rising edge, for exactly one cycle, and change ovr_i only between bus accesses. Flag-clearing sequences are run with the generator stopped, or after deliberately waiting past a reload, so that each scenario has a single expected outcome.

// File: rtl/pwm_reload_pkg.sv
`timescale 1ns/100ps
package pwm_reload_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_MOD  = 2'd2,
        SEL_PW   = 2'd3
    } reg_sel_e;

    // control register bit positions
    localparam int CB_EN   = 0;
    localparam int CB_LOAD = 1;
    localparam int CB_HALF = 2;
    localparam int CB_OVR  = 3;
    localparam int CB_FLAG = 7;
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/100ps
module pwm_regs
    import pwm_reload_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LDFQ_W = 4,
    parameter int PSC_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              reload_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              en_o,
    output logic              half_o,
    output logic              ovr_en_o,
    output logic              flag_o,
    output logic              load_ok_o,
    output logic [LDFQ_W-1:0] ldfq_act_o,
    output logic [PSC_W-1:0]  psc_act_o,
    output logic [CNT_W-1:0]  mod_act_o,
    output logic [CNT_W-1:0]  pw_act_o
);
    localparam int PSC_LSB = LDFQ_W;

    typedef struct packed {
        logic              en;
        logic              load_ok;
        logic              half;
        logic              ovr_en;
        logic              flag;
        logic              clr_arm;
        logic [LDFQ_W-1:0] ldfq_buf;
        logic [LDFQ_W-1:0] ldfq_act;
        logic [PSC_W-1:0]  psc_buf;
        logic [PSC_W-1:0]  psc_act;
        logic [CNT_W-1:0]  mod_buf;
        logic [CNT_W-1:0]  mod_act;
        logic [CNT_W-1:0]  pw_buf;
        logic [CNT_W-1:0]  pw_act;
    } regs_t;

    regs_t    s_d, s_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr_i);

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            case (sel)
                SEL_CTRL: begin
                    s_d.en      = wdata_i[CB_EN];
                    s_d.load_ok = wdata_i[CB_LOAD];
                    s_d.half    = wdata_i[CB_HALF];
                    s_d.ovr_en  = wdata_i[CB_OVR];
                    if (!wdata_i[CB_FLAG] && s_q.clr_arm) begin
                        s_d.flag    = 1'b0;
                        s_d.clr_arm = 1'b0;
                    end
                end
                SEL_CFG: begin
                    s_d.ldfq_buf = wdata_i[0 +: LDFQ_W];
                    s_d.psc_buf  = wdata_i[PSC_LSB +: PSC_W];
                end
                SEL_MOD: s_d.mod_buf = wdata_i[CNT_W-1:0];
                SEL_PW:  s_d.pw_buf  = wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
        // a read that sees the flag set arms the clearing write
        if (rd_en_i && (sel == SEL_CTRL) && s_q.flag) begin
            s_d.clr_arm = 1'b1;
        end
        // a reload always wins over a pending clear
        if (reload_i) begin
            s_d.flag     = 1'b1;
            s_d.clr_arm  = 1'b0;
            s_d.ldfq_act = s_q.ldfq_buf;
            if (s_q.load_ok) begin
                s_d.psc_act = s_q.psc_buf;
                s_d.mod_act = s_q.mod_buf;
                s_d.pw_act  = s_q.pw_buf;
                s_d.load_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_CTRL: begin
                rdata_o[CB_EN]   = s_q.en;
                rdata_o[CB_LOAD] = s_q.load_ok;
                rdata_o[CB_HALF] = s_q.half;
                rdata_o[CB_OVR]  = s_q.ovr_en;
                rdata_o[CB_FLAG] = s_q.flag;
            end
            SEL_CFG: begin
                rdata_o[0 +: LDFQ_W]      = s_q.ldfq_buf;
                rdata_o[PSC_LSB +: PSC_W] = s_q.psc_buf;
            end
            SEL_MOD: rdata_o[CNT_W-1:0] = s_q.mod_buf;
            SEL_PW:  rdata_o[CNT_W-1:0] = s_q.pw_buf;
            default: rdata_o = '0;
        endcase
    end

    assign en_o       = s_q.en;
    assign half_o     = s_q.half;
    assign ovr_en_o   = s_q.ovr_en;
    assign flag_o     = s_q.flag;
    assign load_ok_o  = s_q.load_ok;
    assign ldfq_act_o = s_q.ldfq_act;
    assign psc_act_o  = s_q.psc_act;
    assign mod_act_o  = s_q.mod_act;
    assign pw_act_o   = s_q.pw_act;
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/100ps
module pwm_timebase #(
    parameter int CNT_W  = 8,
    parameter int LDFQ_W = 4,
    parameter int PSC_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              half_i,
    input  logic [CNT_W-1:0]  mod_i,
    input  logic [PSC_W-1:0]  psc_i,
    input  logic [LDFQ_W-1:0] ldfq_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              reload_o
);
    localparam int PSC_CNT_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic [PSC_CNT_W-1:0] psc_cnt;
        logic [CNT_W-1:0]     cnt;
        logic [LDFQ_W-1:0]    opp_cnt;
    } tbase_t;

    tbase_t               s_d, s_q;
    logic [PSC_CNT_W:0]   div_full;
    logic [PSC_CNT_W-1:0] psc_lim;
    logic                 tick, wrap, halfpt, opp;

    always_comb begin
        div_full = (PSC_CNT_W+1)'(1) << psc_i;
        psc_lim  = PSC_CNT_W'(div_full - 1'b1);
        tick     = en_i && (s_q.psc_cnt == psc_lim);
        wrap     = tick && ((mod_i <= CNT_W'(1)) || (s_q.cnt >= (mod_i - CNT_W'(1))));
        halfpt   = tick && half_i && !wrap && ((s_q.cnt + CNT_W'(1)) == (mod_i >> 1));
        opp      = wrap || halfpt;
        reload_o = opp && (s_q.opp_cnt == ldfq_i);

        s_d = s_q;
        if (!en_i) begin
            s_d = '0;
        end else begin
            s_d.psc_cnt = tick ? '0 : s_q.psc_cnt + PSC_CNT_W'(1);
            if (wrap) begin
                s_d.cnt = '0;
            end else if (tick) begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
            if (reload_o) begin
                s_d.opp_cnt = '0;
            end else if (opp) begin
                s_d.opp_cnt = s_q.opp_cnt + LDFQ_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/pwm_drive.sv
`timescale 1ns/100ps
module pwm_drive #(
    parameter int CNT_W = 8
) (
    input  logic             en_i,
    input  logic             ovr_en_i,
    input  logic             ovr_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] pw_i,
    output logic             pwm_o
);
    always_comb begin
        if (ovr_en_i) begin
            pwm_o = ovr_i;
        end else if (en_i) begin
            pwm_o = (cnt_i < pw_i);
        end else begin
            pwm_o = 1'b0;
        end
    end
endmodule

// File: rtl/pwm_reload_gen.sv
`timescale 1ns/100ps
module pwm_reload_gen
    import pwm_reload_pkg::*;
#(
    parameter int LDFQ_W = 4,
    parameter int PSC_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic              ovr_i,
    output logic              pwm_o,
    output logic              irq_o
);
    localparam int CNT_W = BUS_W;

    logic              en, half, ovr_en, flag, load_ok, reload;
    logic [LDFQ_W-1:0] ldfq_act;
    logic [PSC_W-1:0]  psc_act;
    logic [CNT_W-1:0]  mod_act, pw_act, cnt;

    pwm_regs #(.CNT_W(CNT_W), .LDFQ_W(LDFQ_W), .PSC_W(PSC_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .reload_i   (reload),
        .rdata_o    (rdata_o),
        .en_o       (en),
        .half_o     (half),
        .ovr_en_o   (ovr_en),
        .flag_o     (flag),
        .load_ok_o  (load_ok),
        .ldfq_act_o (ldfq_act),
        .psc_act_o  (psc_act),
        .mod_act_o  (mod_act),
        .pw_act_o   (pw_act)
    );

    pwm_timebase #(.CNT_W(CNT_W), .LDFQ_W(LDFQ_W), .PSC_W(PSC_W)) u_tbase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en),
        .half_i   (half),
        .mod_i    (mod_act),
        .psc_i    (psc_act),
        .ldfq_i   (ldfq_act),
        .cnt_o    (cnt),
        .reload_o (reload)
    );

    pwm_drive #(.CNT_W(CNT_W)) u_drive (
        .en_i     (en),
        .ovr_en_i (ovr_en),
        .ovr_i    (ovr_i),
        .cnt_i    (cnt),
        .pw_i     (pw_act),
        .pwm_o    (pwm_o)
    );

    assign irq_o = flag;
endmodule

// File: rtl/pwm_reload_chk.sv
`timescale 1ns/100ps
module pwm_reload_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [1:0]       addr_i,
    input logic [7:0]       wdata_i,
    input logic             ovr_i,
    input logic             pwm_o,
    input logic             reload,
    input logic             flag,
    input logic             load_ok,
    input logic             en,
    input logic             ovr_en,
    input logic [CNT_W-1:0] pw_act,
    input logic [CNT_W-1:0] mod_act
);
    logic clear_try;
    assign clear_try = wr_en_i && (addr_i == 2'd0) && !wdata_i[7];

    assert_flag_on_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload |=> flag);

    assert_load_selfclear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reload && load_ok) |=> !load_ok);

    assert_act_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !reload |=> ($stable(pw_act) && $stable(mod_act)));

    assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag && !clear_try) |=> flag);

    assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en && !ovr_en) |-> !pwm_o);

    assert_override_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_en |-> (pwm_o == ovr_i));

    assert_zero_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && !ovr_en && (pw_act == '0)) |-> !pwm_o);
endmodule

bind pwm_reload_gen pwm_reload_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ovr_i   (ovr_i),
    .pwm_o   (pwm_o),
    .reload  (reload),
    .flag    (flag),
    .load_ok (load_ok),
    .en      (en),
    .ovr_en  (ovr_en),
    .pw_act  (pw_act),
    .mod_act (mod_act)
);

// File: tb/pwm_reload_gen_tb_top.sv
`timescale 1ns/100ps
module pwm_reload_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       ovr = 1'b0;
    logic       pwm;
    logic       irq;

    always #2.5 clk = ~clk;

    pwm_reload_gen dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .rd_en_i (rd_en),
        .wr_en_i (wr_en),
        .ovr_i   (ovr),
        .pwm_o   (pwm),
        .irq_o   (irq)
    );

    typedef enum {K_RD, K_IRQ, K_HI} kind_e;
    typedef struct {
        kind_e kind;
        string tag;
        int    exp;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    hi_cnt = 0;
    logic  hi_win = 1'b0;
    logic  mon_req = 1'b0;

    // monitor: counts high cycles and compares each result against the queue
    always @(negedge clk) begin
        if (hi_win && pwm) hi_cnt++;
        if (rd_en || mon_req) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL scoreboard: result with empty queue, got %0d expected none", rdata);
            end else begin
                item_t it;
                int act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_RD:    act = int'(rdata);
                    K_IRQ:   act = int'(irq);
                    default: act = hi_cnt;
                endcase
                n_chk++;
                if (act != it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %0d expected %0d", it.tag, act, it.exp);
                end
                if (it.kind == K_HI) hi_cnt = 0;
            end
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int e, input string tag);
        exp_q.push_back('{K_RD, tag, e});
        @(posedge clk); #1;
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic irq_chk(input int e, input string tag);
        exp_q.push_back('{K_IRQ, tag, e});
        @(posedge clk); #1;
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    // counts high cycles over the next n cycles from now
    task automatic measure(input int n, input int e, input string tag);
        hi_win = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        hi_win = 1'b0;
        exp_q.push_back('{K_HI, tag, e});
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_chk(2'd0, 8'h00, "R1 control");
        rd_chk(2'd1, 8'h00, "R1 config");
        rd_chk(2'd2, 8'h00, "R1 modulus");
        rd_chk(2'd3, 8'h00, "R1 width");
        irq_chk(0, "R1 irq");
        measure(10, 0, "R1 pwm low");

        // R2 basic duty: modulus 10, width 3, arm and enable
        bus_wr(2'd2, 8'd10);
        bus_wr(2'd3, 8'd3);
        bus_wr(2'd0, 8'h03);
        wait_cyc(20);
        measure(100, 30, "R2 duty 3/10");
        rd_chk(2'd0, 8'h81, "R4 load bit self-cleared, R5 flag set");

        // R3 shadow write without arming has no effect
        bus_wr(2'd3, 8'd7);
        measure(100, 30, "R3 no arm keeps width");
        bus_wr(2'd0, 8'h83);
        wait_cyc(30);
        measure(100, 70, "R3 armed width applied");
        rd_chk(2'd0, 8'h81, "R4 cleared after load");

        // R4 cancel: arm then disarm while stopped
        bus_wr(2'd3, 8'd5);
        bus_wr(2'd0, 8'h82);
        bus_wr(2'd0, 8'h80);
        rd_chk(2'd0, 8'h80, "R4 disarm reads 0");
        measure(20, 0, "R10 stopped output low");
        bus_wr(2'd0, 8'h81);
        wait_cyc(20);
        measure(100, 70, "R4 cancelled load keeps width");

        // R6 clear without prior read is ignored
        wait_cyc(20);
        bus_wr(2'd0, 8'h80);
        bus_wr(2'd0, 8'h00);
        rd_chk(2'd0, 8'h80, "R6 write0 without read ignored");
        bus_wr(2'd0, 8'h00);
        rd_chk(2'd0, 8'h00, "R6 read then write0 clears");
        irq_chk(0, "R6 irq dropped with flag");

        // R7 reload between read and write keeps the flag
        bus_wr(2'd0, 8'h01);
        wait_cyc(30);
        rd_chk(2'd0, 8'h81, "R7 flag set before race");
        wait_cyc(15);
        bus_wr(2'd0, 8'h00);
        rd_chk(2'd0, 8'h80, "R7 intervening reload blocks clear");
        bus_wr(2'd0, 8'h00);
        rd_chk(2'd0, 8'h00, "R7 clean clear");

        // R5 flag set without load arm
        bus_wr(2'd0, 8'h01);
        wait_cyc(30);
        rd_chk(2'd0, 8'h81, "R5 flag without arm");
        irq_chk(1, "R5 irq follows flag");

        // R8 reload every 4th opportunity
        bus_wr(2'd1, 8'h03);
        rd_chk(2'd1, 8'h03, "R8 rate reads shadow");
        wait_cyc(20);
        bus_wr(2'd3, 8'd2);
        bus_wr(2'd0, 8'h82);
        bus_wr(2'd0, 8'h83);
        measure(80, 36, "R8 load at 4th wrap");

        // R9 half opportunity
        bus_wr(2'd3, 8'd6);
        bus_wr(2'd0, 8'h86);
        bus_wr(2'd0, 8'h87);
        measure(80, 40, "R9 half point counts");

        // R11 prescaler divide by 2
        bus_wr(2'd1, 8'h10);
        rd_chk(2'd1, 8'h10, "R11 prescaler field reads back");
        wait_cyc(100);
        bus_wr(2'd3, 8'd3);
        bus_wr(2'd0, 8'h83);
        wait_cyc(60);
        bus_wr(2'd0, 8'h80);
        measure(20, 0, "R10 disabled low");
        bus_wr(2'd0, 8'h81);
        measure(10, 6, "R11 first steps at half rate");

        // R2 extremes of width
        bus_wr(2'd3, 8'd0);
        bus_wr(2'd0, 8'h83);
        wait_cyc(60);
        measure(40, 0, "R2 zero width low");
        bus_wr(2'd3, 8'd12);
        bus_wr(2'd0, 8'h83);
        wait_cyc(60);
        measure(40, 40, "R2 width above modulus high");

        // R10 override
        bus_wr(2'd0, 8'h88);
        ovr = 1'b1;
        measure(20, 20, "R10 override high while stopped");
        ovr = 1'b0;
        measure(20, 0, "R10 override low while stopped");
        bus_wr(2'd0, 8'h89);
        measure(20, 0, "R10 override low while running");

        wait_cyc(4);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule